// File: doc/BRIEF.md
# x87 Condition-Code and Compare-Flag Generator

This block turns the outcome of an already-performed floating-point comparison into the condition bits of the x87 status word, or into the three integer flags (zero, parity, carry) for the compare variants that set flags instead of status bits. It also examines one 80-bit extended-precision value and writes the condition-bit pattern that describes its class: empty, NaN, infinity, zero, denormal or normal. The comparison and the NaN detection on the operands are done upstream. This block only maps their results and reports whether the invalid-operation flag must be raised.

A request is presented with `in_valid`. The operation select, the outcome code, the 80-bit operand, the empty-slot indication, two NaN summary bits and the current status word are captured together. One clock later `out_valid` is high, and the updated status word, the flag triple and the invalid indication are on the outputs. These outputs hold their values until the next request. A parameter can remove the output register so that the mapping is purely combinational.

Top module: `x87cc_flaggen`

## Requirements
- R1: For status compares (op 0 signalling, op 1 quiet), status bits 14, 10 and 8 take the outcome pattern: less (code 0) 0x0100, equal (code 1) 0x4000, greater (code 2) 0x0000, unordered (code 3) 0x4500. Every other bit, bit 9 included, is copied from `sw_in`.
- R2: For flag compares (op 2 signalling, op 3 quiet), `zpc_out` = {ZF,PF,CF} is 001 for less, 100 for equal, 000 for greater and 111 for unordered. `sw_out` equals `sw_in`.
- R3: Signalling compares (ops 0 and 2) set `invalid_out` whenever `nan_any` is set. Quiet compares (ops 1 and 3) set it only when `nan_sig` is set.
- R4: Examine (op 4) clears bits 14, 10, 9 and 8 and then sets bit 9 to the operand sign, which is bit 79. All other status bits are kept, `zpc_out` is 000 and `invalid_out` is 0.
- R5: Examine with exponent (bits 78:64) 0x7FFF and mantissa (bits 63:0) exactly 0x8000000000000000 sets bits 10 and 8. Any other mantissa with that exponent sets bit 8 only.
- R6: Examine with exponent 0 sets bit 14 when the mantissa is 0, and sets bits 14 and 10 when the mantissa is nonzero.
- R7: Examine with any other exponent sets bit 10 only.
- R8: Examine with `slot_empty` set gives bits 14 and 8, whatever the operand value, and bit 9 still follows the sign.
- R9: Op codes 5 to 7 leave `sw_out` equal to `sw_in`, with `zpc_out` 000 and `invalid_out` 0. Status compares also drive `zpc_out` to 000.
- R10: Results appear, with `out_valid` high, exactly one cycle after `in_valid`, and back-to-back requests are accepted every cycle. During reset `out_valid`, `sw_out`, `zpc_out` and `invalid_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation: 0..3 compares, 4 examine, 5..7 no-op |
| cmp_res | input | 2 | Compare outcome: 0 less, 1 equal, 2 greater, 3 unordered |
| nan_any | input | 1 | Some compare operand is a NaN |
| nan_sig | input | 1 | Some compare operand is a signalling NaN |
| opnd | input | 80 | Extended value to examine: sign, exponent, mantissa |
| slot_empty | input | 1 | The examined register slot is empty |
| sw_in | input | 16 | Current status word |
| out_valid | output | 1 | Result strobe |
| sw_out | output | 16 | Updated status word |
| zpc_out | output | 3 | {ZF,PF,CF} for flag compares |
| invalid_out | output | 1 | Invalid-operation indication |

## Verification
The corners that are hardest to reach are the examine encodings that sit right next to each other: a mantissa that differs from the infinity pattern only in its low bit, an all-ones exponent with the integer bit clear, and a zero exponent with only the integer bit set. Each of these must land in a different class than its neighbour. The stimulus builds these operands directly and sends them with both sign values and with the empty flag on and off. The compare paths are driven with all-ones and all-zeros status words, so that any bit written outside the condition positions, or a lost bit 9, shows up as a mismatch.

// File: rtl/x87cc_pkg.sv
package x87cc_pkg;

   localparam int C0_BIT = 8;
   localparam int C1_BIT = 9;
   localparam int C2_BIT = 10;
   localparam int C3_BIT = 14;

   typedef enum logic [2:0] {
      OP_SCMP_SIG   = 3'd0,
      OP_SCMP_QUIET = 3'd1,
      OP_FCMP_SIG   = 3'd2,
      OP_FCMP_QUIET = 3'd3,
      OP_EXAMINE    = 3'd4
   } op_e;

   typedef enum logic [1:0] {
      RES_LT = 2'd0,
      RES_EQ = 2'd1,
      RES_GT = 2'd2,
      RES_UN = 2'd3
   } res_e;

   typedef enum logic [2:0] {
      CLS_NORMAL = 3'd0,
      CLS_INF    = 3'd1,
      CLS_NAN    = 3'd2,
      CLS_ZERO   = 3'd3,
      CLS_DENORM = 3'd4,
      CLS_EMPTY  = 3'd5
   } cls_e;

   typedef struct packed {
      logic c3;
      logic c2;
      logic c1;
      logic c0;
   } ccode_t;

endpackage

// File: rtl/x87cc_cmp_map.sv
module x87cc_cmp_map
   import x87cc_pkg::*;
(
   input  logic [1:0] res,
   input  logic       signalling,
   input  logic       nan_any,
   input  logic       nan_sig,
   output ccode_t     cc,
   output logic [2:0] zpc,
   output logic       inv
);

   res_e res_t;

   always_comb begin
      res_t = res_e'(res);
      cc    = '0;
      zpc   = 3'b000;
      unique case (res_t)
         RES_LT: begin
            cc.c0 = 1'b1;
            zpc   = 3'b001;
         end
         RES_EQ: begin
            cc.c3 = 1'b1;
            zpc   = 3'b100;
         end
         RES_GT: begin
            cc  = '0;
            zpc = 3'b000;
         end
         default: begin
            cc.c3 = 1'b1;
            cc.c2 = 1'b1;
            cc.c0 = 1'b1;
            zpc   = 3'b111;
         end
      endcase
      inv = signalling ? nan_any : nan_sig;
   end

endmodule

// File: rtl/x87cc_classify.sv
module x87cc_classify
   import x87cc_pkg::*;
#(
   parameter int EXP_W  = 15,
   parameter int MANT_W = 64
) (
   input  logic              sign,
   input  logic [EXP_W-1:0]  expo,
   input  logic [MANT_W-1:0] mant,
   input  logic              empty,
   output ccode_t            cc
);

   localparam logic [MANT_W-1:0] INF_MANT = {1'b1, {(MANT_W-1){1'b0}}};

   generate
      if (EXP_W < 2 || MANT_W < 2) begin : g_bad_width
         $error("x87cc_classify: exponent and mantissa need at least two bits");
      end
   endgenerate

   cls_e cls;
   logic exp_max;
   logic exp_min;

   always_comb begin
      exp_max = &expo;
      exp_min = ~|expo;
      if (empty)
         cls = CLS_EMPTY;
      else if (exp_max)
         cls = (mant == INF_MANT) ? CLS_INF : CLS_NAN;
      else if (exp_min)
         cls = (mant == '0) ? CLS_ZERO : CLS_DENORM;
      else
         cls = CLS_NORMAL;
   end

   always_comb begin
      cc    = '0;
      cc.c1 = sign;
      unique case (cls)
         CLS_EMPTY:  begin cc.c3 = 1'b1; cc.c0 = 1'b1; end
         CLS_INF:    begin cc.c2 = 1'b1; cc.c0 = 1'b1; end
         CLS_NAN:    begin cc.c0 = 1'b1; end
         CLS_ZERO:   begin cc.c3 = 1'b1; end
         CLS_DENORM: begin cc.c3 = 1'b1; cc.c2 = 1'b1; end
         default:    begin cc.c2 = 1'b1; end
      endcase
   end

endmodule

// File: rtl/x87cc_merge.sv
module x87cc_merge
   import x87cc_pkg::*;
#(
   parameter int SW_W = 16
) (
   input  logic [2:0]      op,
   input  logic [SW_W-1:0] sw_in,
   input  ccode_t          cc_cmp,
   input  logic [2:0]      zpc_cmp,
   input  logic            inv_cmp,
   input  ccode_t          cc_exam,
   output logic [SW_W-1:0] sw_nxt,
   output logic [2:0]      zpc_nxt,
   output logic            inv_nxt
);

   generate
      if (SW_W <= C3_BIT) begin : g_bad_sw
         $error("x87cc_merge: status word too narrow for condition bits");
      end
   endgenerate

   op_e op_t;

   always_comb begin
      op_t    = op_e'(op);
      sw_nxt  = sw_in;
      zpc_nxt = 3'b000;
      inv_nxt = 1'b0;
      case (op_t)
         OP_SCMP_SIG, OP_SCMP_QUIET: begin
            sw_nxt[C3_BIT] = cc_cmp.c3;
            sw_nxt[C2_BIT] = cc_cmp.c2;
            sw_nxt[C0_BIT] = cc_cmp.c0;
            inv_nxt        = inv_cmp;
         end
         OP_FCMP_SIG, OP_FCMP_QUIET: begin
            zpc_nxt = zpc_cmp;
            inv_nxt = inv_cmp;
         end
         OP_EXAMINE: begin
            sw_nxt[C3_BIT] = cc_exam.c3;
            sw_nxt[C2_BIT] = cc_exam.c2;
            sw_nxt[C1_BIT] = cc_exam.c1;
            sw_nxt[C0_BIT] = cc_exam.c0;
         end
         default: begin
            sw_nxt = sw_in;
         end
      endcase
   end

endmodule

// File: rtl/x87cc_flaggen.sv
module x87cc_flaggen
   import x87cc_pkg::*;
#(
   parameter int SW_W    = 16,
   parameter int EXP_W   = 15,
   parameter int MANT_W  = 64,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [2:0]                   op_sel,
   input  logic [1:0]                   cmp_res,
   input  logic                         nan_any,
   input  logic                         nan_sig,
   input  logic [EXP_W+MANT_W:0]        opnd,
   input  logic                         slot_empty,
   input  logic [SW_W-1:0]              sw_in,
   output logic                         out_valid,
   output logic [SW_W-1:0]              sw_out,
   output logic [2:0]                   zpc_out,
   output logic                         invalid_out
);

   localparam int OPND_W = EXP_W + MANT_W + 1;
   localparam int SIGN_B = OPND_W - 1;
   localparam logic [SW_W-1:0] CMP_MASK =
      (SW_W'(1) << C3_BIT) | (SW_W'(1) << C2_BIT) | (SW_W'(1) << C0_BIT);
   localparam logic [SW_W-1:0] EXAM_MASK = CMP_MASK | (SW_W'(1) << C1_BIT);

   ccode_t          cc_cmp;
   ccode_t          cc_exam;
   logic [2:0]      zpc_cmp;
   logic            inv_cmp;
   logic            signalling;
   logic [SW_W-1:0] sw_nxt;
   logic [2:0]      zpc_nxt;
   logic            inv_nxt;

   assign signalling = (op_sel == OP_SCMP_SIG) || (op_sel == OP_FCMP_SIG);

   x87cc_cmp_map u_cmp (
      .res        (cmp_res),
      .signalling (signalling),
      .nan_any    (nan_any),
      .nan_sig    (nan_sig),
      .cc         (cc_cmp),
      .zpc        (zpc_cmp),
      .inv        (inv_cmp)
   );

   x87cc_classify #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_cls (
      .sign  (opnd[SIGN_B]),
      .expo  (opnd[SIGN_B-1:MANT_W]),
      .mant  (opnd[MANT_W-1:0]),
      .empty (slot_empty),
      .cc    (cc_exam)
   );

   x87cc_merge #(.SW_W(SW_W)) u_merge (
      .op      (op_sel),
      .sw_in   (sw_in),
      .cc_cmp  (cc_cmp),
      .zpc_cmp (zpc_cmp),
      .inv_cmp (inv_cmp),
      .cc_exam (cc_exam),
      .sw_nxt  (sw_nxt),
      .zpc_nxt (zpc_nxt),
      .inv_nxt (inv_nxt)
   );

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid   <= 1'b0;
               sw_out      <= '0;
               zpc_out     <= 3'b000;
               invalid_out <= 1'b0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  sw_out      <= sw_nxt;
                  zpc_out     <= zpc_nxt;
                  invalid_out <= inv_nxt;
               end
            end
         end

         // R10: one-cycle latency
         p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid));

         // R1: status compare touches only bits 14, 10, 8
         p_cmp_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && ($past(op_sel) <= 3'd1))
            |-> ((sw_out & ~CMP_MASK) == ($past(sw_in) & ~CMP_MASK)));

         // R2: flag compare leaves status word alone, flags in legal set
         p_flag_sw_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && (($past(op_sel) == 3'd2) || ($past(op_sel) == 3'd3)))
            |-> ((sw_out == $past(sw_in)) &&
                 ((zpc_out == 3'b001) || (zpc_out == 3'b100) ||
                  (zpc_out == 3'b000) || (zpc_out == 3'b111))));

         // R4: examine sets C1 from sign and keeps other bits
         p_exam_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && ($past(op_sel) == 3'd4))
            |-> ((sw_out[C1_BIT] == $past(opnd[SIGN_B])) &&
                 ((sw_out & ~EXAM_MASK) == ($past(sw_in) & ~EXAM_MASK)) &&
                 !invalid_out));

         // R3: no NaN operand never raises invalid
         p_inv_nan_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !$past(nan_any) && !$past(nan_sig)) |-> !invalid_out);

         // R9: idle op codes pass the status word through
         p_idle_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && ($past(op_sel) >= 3'd5))
            |-> ((sw_out == $past(sw_in)) && (zpc_out == 3'b000) && !invalid_out));
      end else begin : g_comb
         assign out_valid   = in_valid;
         assign sw_out      = sw_nxt;
         assign zpc_out     = zpc_nxt;
         assign invalid_out = inv_nxt;
      end
   endgenerate

endmodule

// File: tb/x87cc_flaggen_bench.sv
module x87cc_flaggen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op_sel = '0;
   logic [1:0]  cmp_res = '0;
   logic        nan_any = 1'b0;
   logic        nan_sig = 1'b0;
   logic [79:0] opnd = '0;
   logic        slot_empty = 1'b0;
   logic [15:0] sw_in = '0;
   logic        out_valid;
   logic [15:0] sw_out;
   logic [2:0]  zpc_out;
   logic        invalid_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [15:0] q_sw[$];
   logic [2:0]  q_zpc[$];
   logic        q_inv[$];
   string       q_tag[$];

   always #2 clk = ~clk;

   x87cc_flaggen u_x87cc_flaggen (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .op_sel      (op_sel),
      .cmp_res     (cmp_res),
      .nan_any     (nan_any),
      .nan_sig     (nan_sig),
      .opnd        (opnd),
      .slot_empty  (slot_empty),
      .sw_in       (sw_in),
      .out_valid   (out_valid),
      .sw_out      (sw_out),
      .zpc_out     (zpc_out),
      .invalid_out (invalid_out)
   );

   task automatic send(input logic [2:0] op, input logic [1:0] res,
                       input logic [79:0] v, input logic emp,
                       input logic na, input logic ns,
                       input logic [15:0] sw, input string tag);
      logic [15:0] e_sw;
      logic [2:0]  e_zpc;
      logic        e_inv;
      logic [14:0] ex;
      logic [63:0] mt;
      e_sw  = sw;
      e_zpc = 3'b000;
      e_inv = 1'b0;
      ex    = v[78:64];
      mt    = v[63:0];
      if (op <= 3'd1) begin
         e_sw = sw & 16'hBAFF;
         case (res)
            2'd0: e_sw = e_sw | 16'h0100;
            2'd1: e_sw = e_sw | 16'h4000;
            2'd2: e_sw = e_sw;
            default: e_sw = e_sw | 16'h4500;
         endcase
         e_inv = (op == 3'd0) ? na : ns;
      end else if (op <= 3'd3) begin
         case (res)
            2'd0: e_zpc = 3'b001;
            2'd1: e_zpc = 3'b100;
            2'd2: e_zpc = 3'b000;
            default: e_zpc = 3'b111;
         endcase
         e_inv = (op == 3'd2) ? na : ns;
      end else if (op == 3'd4) begin
         e_sw = sw & 16'hB8FF;
         if (v[79]) e_sw = e_sw | 16'h0200;
         if (emp)
            e_sw = e_sw | 16'h4100;
         else if (ex == 15'h7FFF)
            e_sw = e_sw | ((mt == 64'h8000_0000_0000_0000) ? 16'h0500 : 16'h0100);
         else if (ex == 15'h0000)
            e_sw = e_sw | ((mt == 64'h0) ? 16'h4000 : 16'h4400);
         else
            e_sw = e_sw | 16'h0400;
      end
      @(negedge clk);
      op_sel     = op;
      cmp_res    = res;
      opnd       = v;
      slot_empty = emp;
      nan_any    = na;
      nan_sig    = ns;
      sw_in      = sw;
      in_valid   = 1'b1;
      q_sw.push_back(e_sw);
      q_zpc.push_back(e_zpc);
      q_inv.push_back(e_inv);
      q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         n_tests++;
         if (q_sw.size() == 0) begin
            n_fail++;
            $display("FAIL R10 unexpected result: out_valid=1 expected no result");
         end else begin
            logic [15:0] e_sw;
            logic [2:0]  e_zpc;
            logic        e_inv;
            string       tg;
            e_sw  = q_sw.pop_front();
            e_zpc = q_zpc.pop_front();
            e_inv = q_inv.pop_front();
            tg    = q_tag.pop_front();
            if (sw_out !== e_sw || zpc_out !== e_zpc || invalid_out !== e_inv) begin
               n_fail++;
               $display("FAIL %s: sw=%h zpc=%b inv=%b expected sw=%h zpc=%b inv=%b",
                        tg, sw_out, zpc_out, invalid_out, e_sw, e_zpc, e_inv);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   localparam logic [79:0] V_ONE    = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
   localparam logic [79:0] V_NEGONE = {1'b1, 15'h3FFF, 64'h8000_0000_0000_0000};

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      n_tests++;
      if (out_valid !== 1'b0 || sw_out !== 16'h0 || zpc_out !== 3'b0 || invalid_out !== 1'b0) begin
         n_fail++;
         $display("FAIL R10 reset: valid=%b sw=%h zpc=%b inv=%b expected 0 0000 000 0",
                  out_valid, sw_out, zpc_out, invalid_out);
      end
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R1: status compare, every outcome, two background words
      for (int r = 0; r < 4; r++) begin
         send(3'd0, 2'(r), V_ONE, 1'b0, 1'b0, 1'b0, 16'hFFFF, "R1 status cmp ones");
         send(3'd1, 2'(r), V_ONE, 1'b0, 1'b0, 1'b0, 16'h0000, "R1 status cmp zeros");
         send(3'd0, 2'(r), V_ONE, 1'b0, 1'b0, 1'b0, 16'h0200, "R1 status cmp keeps bit9");
      end
      // R2: flag compare, every outcome
      for (int r = 0; r < 4; r++) begin
         send(3'd2, 2'(r), V_ONE, 1'b0, 1'b0, 1'b0, 16'hA5C3, "R2 flag cmp signalling");
         send(3'd3, 2'(r), V_ONE, 1'b0, 1'b0, 1'b0, 16'h5A3C, "R2 flag cmp quiet");
      end
      // R3: invalid selection
      send(3'd0, 2'd3, V_ONE, 1'b0, 1'b1, 1'b0, 16'h0000, "R3 signalling qnan");
      send(3'd1, 2'd3, V_ONE, 1'b0, 1'b1, 1'b0, 16'h0000, "R3 quiet qnan");
      send(3'd1, 2'd3, V_ONE, 1'b0, 1'b1, 1'b1, 16'h0000, "R3 quiet snan");
      send(3'd2, 2'd3, V_ONE, 1'b0, 1'b1, 1'b0, 16'h0000, "R3 flag signalling qnan");
      send(3'd3, 2'd3, V_ONE, 1'b0, 1'b1, 1'b0, 16'h0000, "R3 flag quiet qnan");
      send(3'd3, 2'd3, V_ONE, 1'b0, 1'b1, 1'b1, 16'h0000, "R3 flag quiet snan");
      // R4 / R7: examine normal values, sign into bit 9
      send(3'd4, 2'd0, V_ONE, 1'b0, 1'b1, 1'b1, 16'hFFFF, "R4 R7 examine +normal");
      send(3'd4, 2'd0, V_NEGONE, 1'b0, 1'b0, 1'b0, 16'h0000, "R4 R7 examine -normal");
      send(3'd4, 2'd0, {1'b0, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF}, 1'b0, 1'b0, 1'b0, 16'h0000, "R7 largest exponent");
      send(3'd4, 2'd0, {1'b1, 15'h0001, 64'h8000_0000_0000_0000}, 1'b0, 1'b0, 1'b0, 16'h4700, "R7 smallest exponent");
      // R5: infinity and NaN neighbours
      send(3'd4, 2'd0, {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000}, 1'b0, 1'b0, 1'b0, 16'h0000, "R5 +inf");
      send(3'd4, 2'd0, {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000}, 1'b0, 1'b0, 1'b0, 16'hFFFF, "R5 -inf");
      send(3'd4, 2'd0, {1'b0, 15'h7FFF, 64'h8000_0000_0000_0001}, 1'b0, 1'b0, 1'b0, 16'h0000, "R5 nan low bit");
      send(3'd4, 2'd0, {1'b0, 15'h7FFF, 64'hC000_0000_0000_0000}, 1'b0, 1'b0, 1'b0, 16'h0000, "R5 quiet nan");
      send(3'd4, 2'd0, {1'b1, 15'h7FFF, 64'h0000_0000_0000_0000}, 1'b0, 1'b0, 1'b0, 16'h0000, "R5 max exp zero mant");
      // R6: zero and denormal
      send(3'd4, 2'd0, {1'b0, 15'h0000, 64'h0}, 1'b0, 1'b0, 1'b0, 16'h0000, "R6 +zero");
      send(3'd4, 2'd0, {1'b1, 15'h0000, 64'h0}, 1'b0, 1'b0, 1'b0, 16'hFFFF, "R6 -zero");
      send(3'd4, 2'd0, {1'b0, 15'h0000, 64'h0000_0000_0000_0001}, 1'b0, 1'b0, 1'b0, 16'h0000, "R6 denormal lsb");
      send(3'd4, 2'd0, {1'b1, 15'h0000, 64'h8000_0000_0000_0000}, 1'b0, 1'b0, 1'b0, 16'h0000, "R6 denormal int bit");
      // R8: empty overrides class
      send(3'd4, 2'd0, V_ONE, 1'b1, 1'b0, 1'b0, 16'h0000, "R8 empty normal");
      send(3'd4, 2'd0, {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000}, 1'b1, 1'b0, 1'b0, 16'hFFFF, "R8 empty nan neg");
      send(3'd4, 2'd0, {1'b0, 15'h0000, 64'h0}, 1'b1, 1'b0, 1'b0, 16'h0000, "R8 empty zero");
      // R9: unused op codes
      send(3'd5, 2'd3, V_ONE, 1'b1, 1'b1, 1'b1, 16'h1234, "R9 op5 passthrough");
      send(3'd6, 2'd0, V_ONE, 1'b0, 1'b1, 1'b1, 16'hFEDC, "R9 op6 passthrough");
      send(3'd7, 2'd1, V_ONE, 1'b0, 1'b1, 1'b1, 16'h8001, "R9 op7 passthrough");
      idle(1);
      // R10: gap then single request
      idle(3);
      n_tests++;
      if (out_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R10 idle: out_valid=%b expected 0", out_valid);
      end
      send(3'd0, 2'd1, V_ONE, 1'b0, 1'b0, 1'b0, 16'h3800, "R10 after gap");
      idle(4);
      n_tests++;
      if (q_sw.size() != 0) begin
         n_fail++;
         $display("FAIL R10 missing results: pending=%0d expected 0", q_sw.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule